// File: doc/BRIEF.md
# Direct Operand Address Generator

This block forms the 16-bit data-memory operand address for direct-mode instructions in a 16-bit signal-processing datapath. It holds three pieces of state: a 9-bit page register, a 16-bit stack pointer and a one-bit addressing-mode selector. For each valid instruction word it decides whether the operand is direct or indirect. For a direct operand it builds the address in one of two ways. It can place the page above the 7-bit offset carried in the instruction, or it can add that offset to the stack pointer.

The generated address leaves the block through an output register, one cycle after the instruction is presented. It comes with a valid flag and two region flags. One region flag marks the low block of memory-mapped registers and the other marks the small scratch area just above it. The page register, the stack pointer and the mode bit are loaded through their own write strobes. Indirect and circular address generation are handled elsewhere, and so are memory access and instruction fetch.

Top module: `dag_top`

## Requirements
- R1: After the asynchronous active-low reset, the page register, the stack pointer and the mode bit are zero, and all outputs are zero.
- R2: Instruction bit 7 set to 0 marks a direct operand, and bits 6..0 are the offset. Bits 15..8 (the opcode) have no effect on the address or the flags.
- R3: With mode 0, the address is the 9-bit page in bits 15..7 and the offset in bits 6..0.
- R4: With mode 1, the address is the stack pointer plus the zero-extended offset, modulo 65,536.
- R5: A valid instruction with bit 7 set drives `addr_vld_o` low on the next cycle, and `addr_o`, `mmr_o` and `scratch_o` keep their previous values.
- R6: `addr_vld_o` rises exactly one cycle after a valid direct instruction. With no valid instruction, it is low on the next cycle and the address and flags are held.
- R7: A page load (9-bit value) takes effect in the cycle after its strobe. An instruction in the same cycle as the strobe uses the old page.
- R8: A stack-pointer load (16-bit value) takes effect in the cycle after its strobe. An instruction in the same cycle as the strobe uses the old value.
- R9: A mode load takes effect in the cycle after its strobe. An instruction in the same cycle as the strobe uses the old mode.
- R10: `mmr_o` is 1 exactly when the registered address lies in 0x0000..0x005F.
- R11: `scratch_o` is 1 exactly when the registered address lies in 0x0060..0x007F. Both flags are 0 above 0x007F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| page_ld_i | input | 1 | Page register write strobe |
| page_val_i | input | 9 | Short immediate for the page register |
| sp_ld_i | input | 1 | Stack pointer write strobe |
| sp_val_i | input | 16 | New stack pointer value |
| mode_ld_i | input | 1 | Mode bit write strobe |
| mode_val_i | input | 1 | New mode: 0 page-based, 1 stack-relative |
| addr_o | output | 16 | Registered operand address |
| addr_vld_o | output | 1 | Address is from a direct instruction of the previous cycle |
| mmr_o | output | 1 | Address lies in the register-mapped region |
| scratch_o | output | 1 | Address lies in the scratch region |

## Verification
Page-based formation is driven with the offsets 0x05, 0x5F, 0x60 and 0x7F on page 0. These separate the region flags at both of their edges. Formation is then driven with the top page and a nonzero opcode, which exposes any wrong bit placement and any leak of opcode bits into the address. Stack-relative formation is tried with a carry-free sum, a sum that wraps past 0xFFFF, and a sum that lands in the scratch area. Each load strobe is issued in the same cycle as an instruction, which shows whether the new value was used one cycle too early. Indirect words and idle cycles are mixed in to show that the held address is not disturbed.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned OFS_W   = 7;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned IND_BIT = 7;
  localparam int unsigned PAGE_W  = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] MMR_LAST = 16'h005F;
  localparam logic [ADDR_W-1:0] SCR_LAST = 16'h007F;

  typedef enum logic {
    MODE_PAGE = 1'b0,
    MODE_SP   = 1'b1
  } dag_mode_e;
endpackage

// File: rtl/dag_regs.sv
module dag_regs #(
  parameter int unsigned ADDR_W = dag_pkg::ADDR_W,
  parameter int unsigned PAGE_W = dag_pkg::PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_ld_i,
  input  logic [PAGE_W-1:0] page_val_i,
  input  logic              sp_ld_i,
  input  logic [ADDR_W-1:0] sp_val_i,
  input  logic              mode_ld_i,
  input  logic              mode_val_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [ADDR_W-1:0] sp_o,
  output dag_pkg::dag_mode_e mode_o
);
  logic [PAGE_W-1:0]  page_q;
  logic [ADDR_W-1:0]  sp_q;
  dag_pkg::dag_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      sp_q   <= '0;
      mode_q <= dag_pkg::MODE_PAGE;
    end else begin
      if (page_ld_i) page_q <= page_val_i;
      if (sp_ld_i)   sp_q   <= sp_val_i;
      if (mode_ld_i) mode_q <= dag_pkg::dag_mode_e'(mode_val_i);
    end
  end

  assign page_o = page_q;
  assign sp_o   = sp_q;
  assign mode_o = mode_q;

  p_page_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ld_i |=> page_o == $past(page_val_i));
  p_page_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_ld_i |=> $stable(page_o));
  p_sp_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_ld_i |=> sp_o == $past(sp_val_i));
  p_mode_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ld_i |=> mode_o == dag_pkg::dag_mode_e'($past(mode_val_i)));
endmodule

// File: rtl/dag_decode.sv
module dag_decode #(
  parameter int unsigned INSTR_W = dag_pkg::INSTR_W,
  parameter int unsigned OFS_W   = dag_pkg::OFS_W,
  parameter int unsigned IND_BIT = dag_pkg::IND_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               direct_o,
  output logic [OFS_W-1:0]   ofs_o
);
  assign direct_o = ~instr_i[IND_BIT];
  assign ofs_o    = instr_i[OFS_W-1:0];

  // opcode field must never reach the decoded operand fields
  p_opcode_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(instr_i[IND_BIT:0]) && !$stable(instr_i[INSTR_W-1:IND_BIT+1]))
      |-> ($stable(ofs_o) && $stable(direct_o)));
endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc #(
  parameter int unsigned ADDR_W = dag_pkg::ADDR_W,
  parameter int unsigned OFS_W  = dag_pkg::OFS_W,
  parameter int unsigned PAGE_W = ADDR_W - OFS_W
) (
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [ADDR_W-1:0]  sp_i,
  input  dag_pkg::dag_mode_e mode_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] sp_addr;

  assign page_addr = {page_i, ofs_i};
  assign sp_addr   = sp_i + {{EXT_W{1'b0}}, ofs_i};

  always_comb begin
    unique case (mode_i)
      dag_pkg::MODE_SP: addr_o = sp_addr;
      default:          addr_o = page_addr;
    endcase
  end
endmodule

// File: rtl/dag_region.sv
module dag_region #(
  parameter int unsigned       ADDR_W   = dag_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] MMR_LAST = dag_pkg::MMR_LAST,
  parameter logic [ADDR_W-1:0] SCR_LAST = dag_pkg::SCR_LAST
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mmr_o,
  output logic              scr_o
);
  assign mmr_o = (addr_i <= MMR_LAST);
  assign scr_o = (addr_i > MMR_LAST) && (addr_i <= SCR_LAST);

  always_comb begin
    p_region_onehot_r11: assert ($onehot0({mmr_o, scr_o}));
  end
endmodule

// File: rtl/dag_top.sv
module dag_top #(
  parameter int unsigned ADDR_W  = dag_pkg::ADDR_W,
  parameter int unsigned OFS_W   = dag_pkg::OFS_W,
  parameter int unsigned INSTR_W = dag_pkg::INSTR_W,
  parameter int unsigned IND_BIT = dag_pkg::IND_BIT,
  parameter logic [ADDR_W-1:0] MMR_LAST = dag_pkg::MMR_LAST,
  parameter logic [ADDR_W-1:0] SCR_LAST = dag_pkg::SCR_LAST
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       instr_valid_i,
  input  logic [INSTR_W-1:0]         instr_i,
  input  logic                       page_ld_i,
  input  logic [ADDR_W-OFS_W-1:0]    page_val_i,
  input  logic                       sp_ld_i,
  input  logic [ADDR_W-1:0]          sp_val_i,
  input  logic                       mode_ld_i,
  input  logic                       mode_val_i,
  output logic [ADDR_W-1:0]          addr_o,
  output logic                       addr_vld_o,
  output logic                       mmr_o,
  output logic                       scratch_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam int unsigned EXT_W  = ADDR_W - OFS_W;

  logic [PAGE_W-1:0]  page;
  logic [ADDR_W-1:0]  sp;
  dag_pkg::dag_mode_e mode;
  logic               direct;
  logic [OFS_W-1:0]   ofs;
  logic [ADDR_W-1:0]  addr_c;
  logic               mmr_c, scr_c;
  logic               take;

  dag_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni,
    .page_ld_i, .page_val_i,
    .sp_ld_i, .sp_val_i,
    .mode_ld_i, .mode_val_i,
    .page_o(page), .sp_o(sp), .mode_o(mode)
  );

  dag_decode #(.INSTR_W(INSTR_W), .OFS_W(OFS_W), .IND_BIT(IND_BIT)) u_decode (
    .clk_i, .rst_ni,
    .instr_i,
    .direct_o(direct), .ofs_o(ofs)
  );

  dag_addr_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_calc (
    .page_i(page), .sp_i(sp), .mode_i(mode), .ofs_i(ofs),
    .addr_o(addr_c)
  );

  dag_region #(.ADDR_W(ADDR_W), .MMR_LAST(MMR_LAST), .SCR_LAST(SCR_LAST)) u_region (
    .addr_i(addr_c), .mmr_o(mmr_c), .scr_o(scr_c)
  );

  assign take = instr_valid_i & direct;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
      mmr_o      <= 1'b0;
      scratch_o  <= 1'b0;
    end else begin
      addr_vld_o <= take;
      if (take) begin
        addr_o    <= addr_c;
        mmr_o     <= mmr_c;
        scratch_o <= scr_c;
      end
    end
  end

  p_page_form_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode == dag_pkg::MODE_PAGE)
      |=> addr_o == {$past(page), $past(instr_i[OFS_W-1:0])});
  p_sp_form_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode == dag_pkg::MODE_SP)
      |=> addr_o == $past(sp) + {{EXT_W{1'b0}}, $past(instr_i[OFS_W-1:0])});
  p_indirect_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[IND_BIT])
      |=> (!addr_vld_o && $stable(addr_o) && $stable(mmr_o) && $stable(scratch_o)));
  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !instr_i[IND_BIT]) |=> addr_vld_o);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> (!addr_vld_o && $stable(addr_o)));
  p_mmr_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmr_o |-> addr_o <= MMR_LAST);
  p_scr_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scratch_o |-> (addr_o > MMR_LAST && addr_o <= SCR_LAST));
endmodule

// File: tb/dag_top_bench.sv
`timescale 1ns/1ps
module dag_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0;
  logic [15:0] ins = '0;
  logic        pl = 1'b0;
  logic [8:0]  pv = '0;
  logic        sl = 1'b0;
  logic [15:0] sv = '0;
  logic        ml = 1'b0;
  logic        mv = 1'b0;
  logic [15:0] addr;
  logic        vld, mmr, scr;

  always #2 clk = ~clk;

  dag_top u_dag_top (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(iv), .instr_i(ins),
    .page_ld_i(pl), .page_val_i(pv),
    .sp_ld_i(sl), .sp_val_i(sv),
    .mode_ld_i(ml), .mode_val_i(mv),
    .addr_o(addr), .addr_vld_o(vld), .mmr_o(mmr), .scratch_o(scr)
  );

  typedef struct {
    int          cyc;
    logic [15:0] a;
    logic        v, m, s;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [8:0]  m_page = '0;
  logic [15:0] m_sp = '0;
  logic        m_mode = 1'b0;
  logic [15:0] m_addr = '0;
  logic        m_mmr = 1'b0, m_scr = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare the item due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({addr, vld, mmr, scr} == {e.a, e.v, e.m, e.s}, e.req, "addr/vld/mmr/scr",
          {12'h0, addr, vld, mmr, scr}, {12'h0, e.a, e.v, e.m, e.s});
    end
  end

  task automatic step(input logic i_v, input logic [15:0] i_w,
                      input logic p_l, input logic [8:0] p_v,
                      input logic s_l, input logic [15:0] s_v,
                      input logic m_l, input logic m_v, input string req);
    exp_t e;
    @(negedge clk);
    iv = i_v; ins = i_w; pl = p_l; pv = p_v; sl = s_l; sv = s_v; ml = m_l; mv = m_v;
    e.v = i_v && !i_w[7];
    if (e.v) begin
      m_addr = m_mode ? m_sp + {9'h0, i_w[6:0]} : {m_page, i_w[6:0]};
      m_mmr  = m_addr <= 16'h005F;
      m_scr  = m_addr >= 16'h0060 && m_addr <= 16'h007F;
    end
    e.cyc = cyc + 1; e.a = m_addr; e.m = m_mmr; e.s = m_scr; e.req = req;
    q.push_back(e);
    if (p_l) m_page = p_v;
    if (s_l) m_sp = s_v;
    if (m_l) m_mode = m_v;
  endtask

  task automatic instr(input logic [15:0] w, input string req);
    step(1'b1, w, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({addr, vld, mmr, scr} == '0, "R1", "outputs after reset",
        {12'h0, addr, vld, mmr, scr}, 32'h0);
    // R1: page and mode reset to zero, seen through a page-mode address
    instr(16'h0005, "R1 R3 R10 reset page/mode");
    instr(16'h005F, "R10 mmr upper edge");
    instr(16'h0060, "R11 scratch lower edge");
    instr(16'h007F, "R11 scratch upper edge");
    instr(16'h3C80, "R5 indirect holds");
    step(1'b0, 16'h0011, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R6 idle holds");
    // R7: page load with a same-cycle instruction that still sees page 0
    step(1'b1, 16'h0010, 1'b1, 9'h1FF, 1'b0, '0, 1'b0, 1'b0, "R7 old page in load cycle");
    instr(16'h007F, "R7 R3 new page top");
    instr(16'hAB05, "R2 opcode ignored");
    instr(16'h5405, "R2 other opcode same addr");
    instr(16'h0085, "R5 indirect after top page");
    // R8 R9: sp and mode loads, same-cycle instruction still page mode
    step(1'b1, 16'h0001, 1'b0, '0, 1'b1, 16'h1234, 1'b1, 1'b1, "R8 R9 old mode/sp in load cycle");
    instr(16'h007F, "R4 R8 R9 sp plus offset");
    step(1'b1, 16'h0000, 1'b0, '0, 1'b1, 16'hFFF0, 1'b0, 1'b0, "R8 old sp in load cycle");
    instr(16'h0020, "R4 R10 wrap to 0x0010");
    step(1'b0, 16'h0000, 1'b0, '0, 1'b1, 16'h0040, 1'b0, 1'b0, "R6 idle during sp load");
    instr(16'hFF20, "R4 R11 sp lands in scratch");
    instr(16'h0080, "R5 indirect in sp mode");
    step(1'b1, 16'h0001, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R9 sp mode in load cycle");
    instr(16'h0001, "R9 R3 back to page mode");
    step(1'b0, 16'h0000, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R6 final idle");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R6", "queue drained", q.size(), 0);
    done = 1;
    summary();
  end
endmodule